// File: doc/BRIEF.md
# Page-Table Address Translation Unit

This block turns an 8-bit virtual address into a 12-bit physical address. The top bit of the virtual address picks the mode. When it is set, the address is passed straight through: the low seven bits become the physical address, so those results always lie in 0x000 to 0x07F. When it is clear, bits 6:4 name one of eight pages and bits 3:0 give the byte offset within a 16-byte page. The page's entry in an on-chip table supplies an 8-bit frame number, and the frame number sits above the offset to form the 12-bit result.

Each table entry is 9 bits wide: a valid flag in bit 8 and a frame number in bits 7:0. A host loads entries through a write port, one entry per clock. A translated request whose entry is not valid returns a fault instead of an address.

Requests use a valid/ready handshake. The answer is registered and appears as a one-cycle response on the clock after the request is accepted. There is no back-pressure on the response side.

Top module: `pt_xlate_unit`

## Requirements
- R1: An accepted request with vaddr bit 7 = 1 answers paddr = {5'b0, vaddr[6:0]} with fault = 0, whatever the table holds.
- R2: An accepted request with vaddr bit 7 = 0, whose entry at index vaddr[6:4] has bit 8 (valid) = 1, answers paddr = {entry[7:0], vaddr[3:0]} with fault = 0. For example, entry 6 = {1, 0xDD} maps 0x63 to 0xDD3.
- R3: An accepted translated request whose entry has valid = 0 answers fault = 1 and paddr = 0.
- R4: rsp_valid_o is high exactly on the cycle after a request is accepted (req_valid_i and req_ready_o both high at a clock edge). While rsp_valid_o is low, rsp_paddr_o and rsp_fault_o are 0.
- R5: When wr_en_i is high at a clock edge, entry wr_idx_i takes wr_data_i (bit 8 = valid, bits 7:0 = frame). Requests accepted at later edges use the new entry.
- R6: A write and a request accepted at the same edge that address the same entry produce a response built from the entry as it was before the write.
- R7: Reset (rst_ni low) clears every entry's valid bit and any pending response. After reset, every translated request faults until its entry is written.
- R8: Writes and invalid entries have no effect on the answer to a request in bypass mode.
- R9: req_ready_o is low while in reset and from the first clock edge after reset it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_vaddr_i | input | 8 | Virtual address |
| wr_en_i | input | 1 | Table write enable |
| wr_idx_i | input | 3 | Entry index to write |
| wr_data_i | input | 9 | Entry value: bit 8 valid, bits 7:0 frame |
| rsp_valid_o | output | 1 | Response valid, one cycle after acceptance |
| rsp_paddr_o | output | 12 | Physical address (0 on fault) |
| rsp_fault_o | output | 1 | Translation fault |

## Verification
A table write and a translation can land in the same cycle, and when they address the same entry the response must reflect the old contents. The bench provokes this on purpose. It rewrites entry 6 while translating 0x63 at the same edge, and it invalidates an entry while a request for it is in flight. Random traffic adds many more such collisions. A behavioural model updates its table only after it has formed the cycle's answer, and each response is judged against that model on every clock. Both orderings are therefore covered: the old value must come back at the colliding edge, and the new value must come back afterwards.

// File: rtl/pt_pkg.sv
package pt_pkg;
  parameter int unsigned VA_W    = 8;
  parameter int unsigned PAGE_W  = 3;
  parameter int unsigned OFF_W   = 4;
  parameter int unsigned FRAME_W = 8;
  localparam int unsigned PA_W    = FRAME_W + OFF_W;
  localparam int unsigned N_PAGES = 1 << PAGE_W;
  localparam int unsigned DIR_W   = VA_W - 1;

  typedef struct packed {
    logic               valid;
    logic [FRAME_W-1:0] frame;
  } pte_t;

  typedef struct packed {
    logic [PA_W-1:0] paddr;
    logic            fault;
  } xres_t;
endpackage

// File: rtl/pt_store.sv
module pt_store
  import pt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PAGE_W-1:0] wr_idx_i,
  input  pte_t              wr_data_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output pte_t              rd_pte_o
);
  pte_t ent_q [N_PAGES];

  for (genvar g = 0; g < N_PAGES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[g] <= '0;
      end else if (wr_en_i && (wr_idx_i == PAGE_W'(g))) begin
        ent_q[g] <= wr_data_i;
      end
    end
  end

  // read is combinational: same-edge write is seen by the response as old data
  assign rd_pte_o = ent_q[rd_idx_i];
endmodule

// File: rtl/pt_map.sv
module pt_map
  import pt_pkg::*;
(
  input  logic [VA_W-1:0]   vaddr_i,
  input  pte_t              pte_i,
  output logic [PAGE_W-1:0] page_o,
  output xres_t             res_o
);
  logic            direct;
  logic [OFF_W-1:0] offset;

  assign direct = vaddr_i[VA_W-1];
  assign page_o = vaddr_i[OFF_W +: PAGE_W];
  assign offset = vaddr_i[OFF_W-1:0];

  always_comb begin
    res_o = '0;
    if (direct) begin
      res_o.paddr = PA_W'(vaddr_i[DIR_W-1:0]);
    end else if (pte_i.valid) begin
      res_o.paddr = {pte_i.frame, offset};
    end else begin
      res_o.fault = 1'b1;
    end
  end
endmodule

// File: rtl/pt_resp.sv
module pt_resp
  import pt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  accept_i,
  input  xres_t res_i,
  output logic  ready_o,
  output logic  valid_o,
  output xres_t res_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o <= 1'b0;
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      ready_o <= 1'b1;
      valid_o <= accept_i;
      res_o   <= accept_i ? res_i : '0;
    end
  end
endmodule

// File: rtl/pt_xlate_unit.sv
module pt_xlate_unit
  import pt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_vaddr_i,
  input  logic               wr_en_i,
  input  logic [PAGE_W-1:0]  wr_idx_i,
  input  logic [FRAME_W:0]   wr_data_i,
  output logic               rsp_valid_o,
  output logic [PA_W-1:0]    rsp_paddr_o,
  output logic               rsp_fault_o
);
  logic [PAGE_W-1:0] page;
  pte_t              pte;
  xres_t             res_d, res_q;
  logic              accept;

  assign accept = req_valid_i && req_ready_o;

  pt_store i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (pte_t'(wr_data_i)),
    .rd_idx_i  (page),
    .rd_pte_o  (pte)
  );

  pt_map i_map (
    .vaddr_i (req_vaddr_i),
    .pte_i   (pte),
    .page_o  (page),
    .res_o   (res_d)
  );

  pt_resp i_resp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .res_i    (res_d),
    .ready_o  (req_ready_o),
    .valid_o  (rsp_valid_o),
    .res_o    (res_q)
  );

  assign rsp_paddr_o = res_q.paddr;
  assign rsp_fault_o = res_q.fault;
endmodule

// File: rtl/pt_xlate_unit_chk.sv
module pt_xlate_unit_chk
  import pt_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic [VA_W-1:0]    req_vaddr_i,
  input logic               rsp_valid_o,
  input logic [PA_W-1:0]    rsp_paddr_o,
  input logic               rsp_fault_o
);
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o); // R4
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !rsp_valid_o); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_fault_o && rsp_paddr_o == '0)); // R4
  AST_DIRECT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_vaddr_i[VA_W-1]) |=>
      (!rsp_fault_o && rsp_paddr_o == PA_W'($past(req_vaddr_i[DIR_W-1:0])))); // R1
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !req_vaddr_i[VA_W-1]) |=>
      (rsp_fault_o || rsp_paddr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0]))); // R2
  AST_FAULT_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_paddr_o == '0); // R3
  AST_READY_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> req_ready_o); // R9
endmodule

bind pt_xlate_unit pt_xlate_unit_chk i_chk (.*);

// File: tb/test_pt_xlate_unit.sv
module test_pt_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_vaddr = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [8:0]  wr_data = '0;
  logic        rsp_valid;
  logic [11:0] rsp_paddr;
  logic        rsp_fault;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string tag = "R7";

  // behavioural model
  logic [8:0]  m_tbl [8];
  logic        m_ready = 1'b0;
  logic        m_valid = 1'b0;
  logic [11:0] m_paddr = '0;
  logic        m_fault = 1'b0;
  string       m_tag = "R4";

  always #10 clk = ~clk;

  pt_xlate_unit i_pt_xlate_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_tbl[i] = '0;
      m_ready = 1'b0; m_valid = 1'b0; m_paddr = '0; m_fault = 1'b0;
    end else begin
      m_valid = req_valid && m_ready;
      m_paddr = '0; m_fault = 1'b0;
      if (m_valid) begin
        if (req_vaddr[7]) begin
          m_paddr = {5'b0, req_vaddr[6:0]};
          m_tag = (tag == "R8") ? "R8" : "R1";
        end else if (m_tbl[req_vaddr[6:4]][8]) begin
          m_paddr = {m_tbl[req_vaddr[6:4]][7:0], req_vaddr[3:0]};
          m_tag = (tag == "R1") ? "R2" : tag;
        end else begin
          m_fault = 1'b1;
          m_tag = (tag == "R1") ? "R3" : tag;
        end
      end else m_tag = "R4";
      if (wr_en) m_tbl[wr_idx] = wr_data;  // after the read: old entry wins
      m_ready = 1'b1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic compare();
    checks++;
    if (rsp_valid !== m_valid || rsp_paddr !== m_paddr || rsp_fault !== m_fault) begin
      failures++;
      $display("FAIL %s: got v=%b pa=%h f=%b exp v=%b pa=%h f=%b", m_tag,
               rsp_valid, rsp_paddr, rsp_fault, m_valid, m_paddr, m_fault);
    end
    checks++;
    if (req_ready !== m_ready) begin
      failures++;
      $display("FAIL R9: ready got %b exp %b", req_ready, m_ready);
    end
  endtask

  // one clock: compare at negedge, then drive the next inputs
  task automatic step(input logic v, input logic [7:0] va, input logic we,
                      input logic [2:0] wi, input logic [8:0] wd);
    @(negedge clk);
    compare();
    req_valid = v; req_vaddr = va; wr_en = we; wr_idx = wi; wr_data = wd;
  endtask

  task automatic rd(input logic [7:0] va);
    step(1'b1, va, 1'b0, '0, '0);
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, '0, '0);
  endtask

  task automatic direct_check(input logic [7:0] va, input logic [11:0] pa, input logic f,
                              input string t);
    @(negedge clk);
    compare();
    checks++;
    if (rsp_paddr !== pa || rsp_fault !== f || rsp_valid !== 1'b1) begin
      failures++;
      $display("FAIL %s: va %h got pa=%h f=%b exp pa=%h f=%b", t, va, rsp_paddr, rsp_fault, pa, f);
    end
    req_valid = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    logic [8:0] dflt [8];
    dflt[0] = 9'h1FF; dflt[1] = 9'h000; dflt[2] = 9'h0A0; dflt[3] = 9'h108;
    dflt[4] = 9'h1B0; dflt[5] = 9'h1EE; dflt[6] = 9'h1DD; dflt[7] = 9'h0FF;

    // R7 R9: reset state
    repeat (2) @(negedge clk);
    checks++;
    if (req_ready !== 1'b0 || rsp_valid !== 1'b0) begin
      failures++;
      $display("FAIL R9: in reset ready=%b valid=%b exp 0 0", req_ready, rsp_valid);
    end
    rst_n = 1'b1;
    tag = "R7";
    for (int i = 0; i < 8; i++) rd({1'b0, i[2:0], 4'h5});
    idle();

    // R5: load table
    tag = "R5";
    for (int i = 0; i < 8; i++) step(1'b0, '0, 1'b1, i[2:0], dflt[i]);
    idle();
    tag = "R1";
    rd(8'h63); direct_check(8'h63, 12'hDD3, 1'b0, "R2");
    rd(8'h00); direct_check(8'h00, 12'hFF0, 1'b0, "R2");
    rd(8'h3C); direct_check(8'h3C, 12'h08C, 1'b0, "R2");
    rd(8'h40); direct_check(8'h40, 12'hB00, 1'b0, "R2");
    rd(8'h1A); direct_check(8'h1A, 12'h000, 1'b1, "R3");
    rd(8'h7F); direct_check(8'h7F, 12'h000, 1'b1, "R3");
    rd(8'h80); direct_check(8'h80, 12'h000, 1'b0, "R1");
    rd(8'hFF); direct_check(8'hFF, 12'h07F, 1'b0, "R1");

    // R6: write entry 6 while translating it
    tag = "R6";
    step(1'b1, 8'h63, 1'b1, 3'd6, 9'h112);
    direct_check(8'h63, 12'hDD3, 1'b0, "R6");
    rd(8'h63); direct_check(8'h63, 12'h123, 1'b0, "R5");
    step(1'b1, 8'h05, 1'b1, 3'd0, 9'h000);
    direct_check(8'h05, 12'hFF5, 1'b0, "R6");
    rd(8'h05); direct_check(8'h05, 12'h000, 1'b1, "R5");

    // R8: bypass ignores table and writes
    tag = "R8";
    step(1'b1, 8'hA5, 1'b1, 3'd2, 9'h1AB);
    direct_check(8'hA5, 12'h025, 1'b0, "R8");
    step(1'b1, 8'hF0, 1'b1, 3'd7, 9'h000);
    direct_check(8'hF0, 12'h070, 1'b0, "R8");

    // R4: back-to-back and gapped
    tag = "R4";
    rd(8'h51); rd(8'h52); idle(); rd(8'h81); idle(); idle();

    // random traffic with colliding writes
    tag = "R1";
    for (int n = 0; n < 600; n++)
      step(1'($urandom), 8'($urandom), 1'($urandom), 3'($urandom), 9'($urandom));
    idle();

    // R7: reset mid-run clears entries
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b0) begin
      failures++;
      $display("FAIL R7: after reset valid=%b ready=%b exp 0 0", rsp_valid, req_ready);
    end
    rst_n = 1'b1;
    tag = "R7";
    idle();
    for (int i = 0; i < 8; i++) begin
      rd({1'b0, i[2:0], 4'h0});
      direct_check({1'b0, i[2:0], 4'h0}, 12'h000, 1'b1, "R7");
    end
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule